// File: doc/BRIEF.md
# Manchester three-tone FSK modulator

This block turns a serial stream of symbols at 9600 bit/s into a square-wave frequency-shift-keyed line signal. Each data bit is Manchester coded, so every bit carries a mid-bit transition. Each half-bit level then selects one of two tones: 230.4 kHz for a low level and 115.2 kHz for a high level. A frame-start symbol uses a third tone. That tone depends on the direction of travel: 460.8 kHz when the central station sends and 57.6 kHz when a remote station answers.

All timing comes from a single clock enable at 921.6 kHz. Each half-bit lasts 48 enabled ticks. Every tone divides evenly into a half-bit and completes an even number of toggles in it. The line therefore returns low at every half-bit boundary, and tone switches never break the phase.

The source presents a symbol on `bit_valid` together with `bit_data`, `start_sym` and `dir_sel`. The block takes it on a tick-enabled cycle while `bit_ready` is high. `bit_ready` is high when the block is idle and during the final tick of the current bit, so a frame can be streamed with no gap between bits. When the last bit ends with nothing queued, `done` pulses and the line stays low.

Top module: `fsk_manchester_mod`

## Requirements
- R1: While reset is asserted and right after its release, `line` and `done` are low and `bit_ready` is high.
- R2: While idle, `line` stays low. `bit_valid` is acted on only on a cycle where `tick_en` and `bit_ready` are both high; at any other time it has no effect on `line` or on the bit timing.
- R3: A data bit 0 (`start_sym`=0, `bit_data`=0) sends its first half at the high-level tone (line toggles every 4 ticks) and its second half at the low-level tone (toggles every 2 ticks).
- R4: A data bit 1 (`start_sym`=0, `bit_data`=1) sends its first half at the low-level tone (toggles every 2 ticks) and its second half at the high-level tone (toggles every 4 ticks).
- R5: A start symbol with `dir_sel`=0 (central to remote) toggles the line on every tick for a whole bit time, with no mid-bit change. `start_sym` takes priority over `bit_data`.
- R6: A start symbol with `dir_sel`=1 (remote to central) toggles the line every 8 ticks for a whole bit time. `dir_sel` affects only start symbols.
- R7: Each half-bit is 48 ticks, so each symbol is 96 ticks. The line is low at the end of every half-bit, and tone changes keep phase continuity.
- R8: `bit_ready` is low during the first 95 ticks of a symbol and high during its 96th tick. A symbol accepted on that tick begins on the very next tick, with no gap.
- R9: When a symbol's final tick passes with no new symbol accepted, `done` is high for exactly one clock cycle. At that point the block is idle and `line` is low.
- R10: `line` changes only on clock cycles where `tick_en` is high.
- R11: A symbol accepted from idle spends its acceptance tick with the line low, and the block is busy from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Clock enable at 921.6 kHz; one pulse per line tick |
| bit_valid | input | 1 | A symbol is presented on the symbol inputs |
| bit_data | input | 1 | Data bit value for a data symbol |
| start_sym | input | 1 | Presented symbol is a frame-start symbol |
| dir_sel | input | 1 | Start tone select: 0 central sender, 1 remote sender |
| line | output | 1 | Modulated square-wave line signal |
| done | output | 1 | One-cycle pulse at the end of the last queued symbol |
| bit_ready | output | 1 | Block can take a symbol on the current tick |

## Verification
On every cycle, the assertions check the properties that hold at all times: the line is low whenever the block is idle, it changes only on enabled ticks, `done` is a single-cycle pulse that leaves the block idle with the line low, and an accepted symbol always makes the block busy. Tone periods, the order of the two Manchester halves for 0 and 1, the direction-dependent start tone, the 48-tick half-bit length and gap-free streaming are shown only by the bench. It predicts the line value after every tick for every symbol kind, and for every ordered pair of kinds, at irregular tick spacing.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO      = 2'd0,
    SYM_ONE       = 2'd1,
    SYM_START_CEN = 2'd2,
    SYM_START_PER = 2'd3
  } sym_kind_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fsk_half_timer.sv
module fsk_half_timer #(
  parameter int HALF_TICKS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic accept,
  output logic active,
  output logic half,
  output logic last_tick,
  output logic done
);

  localparam int CNTW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(HALF_TICKS - 1);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            active_d, half_d, done_d;

  assign last_tick = active && half && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active;
    half_d   = half;
    done_d   = 1'b0;
    if (tick_en) begin
      if (accept) begin
        active_d = 1'b1;
        half_d   = 1'b0;
        cnt_d    = '0;
      end else if (active) begin
        if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          if (half) begin
            active_d = 1'b0;
            half_d   = 1'b0;
            done_d   = 1'b1;
          end else begin
            half_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      active <= 1'b0;
      half   <= 1'b0;
      done   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      active <= active_d;
      half   <= half_d;
      done   <= done_d;
    end
  end

endmodule

// File: rtl/fsk_tone_sel.sv
module fsk_tone_sel
  import fsk_mod_pkg::*;
#(
  parameter int DIV_LOW_LVL   = 2,
  parameter int DIV_HIGH_LVL  = 4,
  parameter int DIV_START_CEN = 1,
  parameter int DIV_START_PER = 8,
  parameter int DIVW          = 4
) (
  input  sym_kind_e        kind,
  input  logic             half,
  output logic [DIVW-1:0]  divisor
);

  always_comb begin
    case (kind)
      SYM_ZERO:      divisor = half ? DIVW'(DIV_LOW_LVL)  : DIVW'(DIV_HIGH_LVL);
      SYM_ONE:       divisor = half ? DIVW'(DIV_HIGH_LVL) : DIVW'(DIV_LOW_LVL);
      SYM_START_CEN: divisor = DIVW'(DIV_START_CEN);
      SYM_START_PER: divisor = DIVW'(DIV_START_PER);
      default:       divisor = DIVW'(DIV_LOW_LVL);
    endcase
  end

endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            restart,
  input  logic [DIVW-1:0] divisor,
  output logic            line
);

  logic [DIVW-1:0] phase_q, phase_d;
  logic            line_d;

  always_comb begin
    phase_d = phase_q;
    line_d  = line;
    if (step) begin
      if (phase_q == (divisor - DIVW'(1))) begin
        phase_d = '0;
        line_d  = ~line;
      end else begin
        phase_d = phase_q + DIVW'(1);
      end
    end
    if (restart) begin
      phase_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      line    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      line    <= line_d;
    end
  end

endmodule

// File: rtl/fsk_manchester_mod.sv
module fsk_manchester_mod
  import fsk_mod_pkg::*;
#(
  parameter int HALF_TICKS    = 48,
  parameter int DIV_LOW_LVL   = 2,
  parameter int DIV_HIGH_LVL  = 4,
  parameter int DIV_START_CEN = 1,
  parameter int DIV_START_PER = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic start_sym,
  input  logic dir_sel,
  output logic line,
  output logic done,
  output logic bit_ready
);

  localparam int DIV_MAX = max4(DIV_LOW_LVL, DIV_HIGH_LVL, DIV_START_CEN, DIV_START_PER);
  localparam int DIVW    = $clog2(DIV_MAX + 1);

  logic            active, half, last_tick, accept, step;
  sym_kind_e       kind_in, sym_q, sym_d;
  logic [DIVW-1:0] divisor;

  // Symbol classification: a start marker wins over the data bit.
  always_comb begin
    if (start_sym) kind_in = dir_sel ? SYM_START_PER : SYM_START_CEN;
    else           kind_in = bit_data ? SYM_ONE : SYM_ZERO;
  end

  assign bit_ready = !active || last_tick;
  assign accept    = tick_en && bit_valid && bit_ready;
  assign step      = tick_en && active;

  always_comb begin
    sym_d = sym_q;
    if (accept) sym_d = kind_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sym_q <= SYM_ZERO;
    else        sym_q <= sym_d;
  end

  fsk_half_timer #(
    .HALF_TICKS (HALF_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .accept    (accept),
    .active    (active),
    .half      (half),
    .last_tick (last_tick),
    .done      (done)
  );

  fsk_tone_sel #(
    .DIV_LOW_LVL   (DIV_LOW_LVL),
    .DIV_HIGH_LVL  (DIV_HIGH_LVL),
    .DIV_START_CEN (DIV_START_CEN),
    .DIV_START_PER (DIV_START_PER),
    .DIVW          (DIVW)
  ) u_sel (
    .kind    (sym_q),
    .half    (half),
    .divisor (divisor)
  );

  fsk_tone_gen #(
    .DIVW (DIVW)
  ) u_tone (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .restart (accept),
    .divisor (divisor),
    .line    (line)
  );

endmodule

// File: rtl/fsk_mod_checker.sv
module fsk_mod_checker (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic bit_valid,
  input logic line,
  input logic done,
  input logic bit_ready,
  input logic busy
);

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line); // R2

  AST_LINE_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(line)); // R10

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !line)); // R9

  AST_ACCEPT_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && bit_valid && bit_ready) |=> busy); // R11

  AST_IDLE_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bit_ready); // R8

endmodule

bind fsk_manchester_mod fsk_mod_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bit_valid (bit_valid),
  .line      (line),
  .done      (done),
  .bit_ready (bit_ready),
  .busy      (active)
);

// File: tb/fsk_manchester_mod_tb.sv
module fsk_manchester_mod_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, tick_en, bit_valid, bit_data, start_sym, dir_sel;
  logic line, done, bit_ready;

  int n_chk  = 0;
  int n_fail = 0;
  int gap_sel = 0;
  int frame_q[$];

  fsk_manchester_mod u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .start_sym (start_sym),
    .dir_sel   (dir_sel),
    .line      (line),
    .done      (done),
    .bit_ready (bit_ready)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Kinds: 0 = data 0, 1 = data 1, 2 = start central, 3 = start remote.
  function automatic int tone_div(input int kind, input int h);
    case (kind)
      0:       return (h == 0) ? 4 : 2;
      1:       return (h == 0) ? 2 : 4;
      2:       return 1;
      default: return 8;
    endcase
  endfunction

  function automatic string kind_tag(input int kind);
    case (kind)
      0:       return "R3";
      1:       return "R4";
      2:       return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic drive_kind(input int kind, input logic v);
    bit_valid = v;
    start_sym = (kind >= 2);
    if (kind == 3)      dir_sel = 1'b1;
    else if (kind == 2) dir_sel = 1'b0;
    else                dir_sel = gap_sel[0];
    if (kind < 2) bit_data = (kind == 1);
    else          bit_data = gap_sel[1];
  endtask

  task automatic tick(input string line_req, input logic exp_ready,
                      input logic exp_line, input logic exp_done);
    int gap;
    @(negedge clk);
    check("R8", bit_ready, exp_ready);
    tick_en = 1'b1;
    @(posedge clk);
    #1;
    check(line_req, line, exp_line);
    check("R9", done, exp_done);
    @(negedge clk);
    tick_en = 1'b0;
    gap = gap_sel % 3;
    gap_sel++;
    for (int g = 0; g < gap; g++) begin
      @(posedge clk);
      #1;
      check("R10", line, exp_line);
      check("R9", done, 1'b0);
    end
  endtask

  task automatic run_frame();
    int nsym;
    nsym = frame_q.size();
    drive_kind(frame_q[0], 1'b1);
    tick("R11", 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < nsym; i++) begin
      for (int k = 0; k < 96; k++) begin
        int h, t, d;
        string tag;
        h = k / 48;
        t = k % 48;
        d = tone_div(frame_q[i], h);
        if (k == 95) begin
          if (i + 1 < nsym) drive_kind(frame_q[i+1], 1'b1);
          else              bit_valid = 1'b0;
        end else if (k == 1 || k == 50) begin
          drive_kind((i + k) % 4, 1'b1);   // ignored mid-bit (R2)
        end else if (k == 2) begin
          bit_valid = 1'b0;
        end
        tag = (t == 47) ? "R7" : kind_tag(frame_q[i]);
        tick(tag, (k == 95), logic'(((t + 1) / d) % 2),
             (k == 95) && (i == nsym - 1));
      end
    end
    bit_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bit_valid = 1'b0;
    bit_data = 1'b0; start_sym = 1'b0; dir_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", line, 1'b0);
    check("R1", done, 1'b0);
    check("R1", bit_ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", line, 1'b0);
    check("R1", bit_ready, 1'b1);

    // R2: valid without tick enable does nothing
    @(negedge clk);
    bit_valid = 1'b1; start_sym = 1'b1;
    repeat (5) begin
      @(posedge clk);
      #1;
      check("R2", line, 1'b0);
      check("R2", bit_ready, 1'b1);
    end
    @(negedge clk);
    bit_valid = 1'b0;
    tick("R2", 1'b1, 1'b0, 1'b0);
    tick("R2", 1'b1, 1'b0, 1'b0);

    // Each kind alone
    for (int a = 0; a < 4; a++) begin
      frame_q = {a};
      run_frame();
    end

    // Every ordered pair of kinds
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        frame_q = {a, b};
        run_frame();
      end
    end

    // A longer frame
    frame_q = {2, 0, 1, 1, 0, 3};
    run_frame();
    tick("R2", 1'b1, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule